// File: doc/BRIEF.md
# Programmable Serial Bit-Delay Sampler

This block realigns one serial time-division input stream against its frame boundary. It runs from a local clock at four times the bit rate, so each bit cell spans four clock phases. A frame-start pulse marks the phase in which the first quarter of bit 0 arrives. A bank of per-stream 5-bit delay fields sits behind a simple write/read configuration port. At each frame start a stream select picks one entry, and that entry together with a global mode input sets how many quarter-bit phases pass before bit 0 is captured. After that first capture the block takes one sample every four phases. Each captured bit goes out with a one-cycle valid strobe and its index within the frame.

The 5-bit field is read in two ways. In fractional mode (mode input low) the whole field is a delay in quarter bits, and the sample is taken at the three-quarter point of the cell. In split mode (mode input high) the upper three bits are a whole-bit delay and the lower two bits pick one of four sampling points in the cell. Settings are captured only at a frame start, so one frame is never sampled with two different configurations.

Top module: `bit_delay_sampler`

## Requirements
- R1: After reset every delay field reads as zero and no bit strobe is issued until a frame start has been seen.
- R2: A configuration read returns the stored 5-bit field in bits 4:0 and zero in bits 15:5; bits 15:5 of a write are discarded.
- R3: With the mode input low, bit 0 of a frame is captured at phase 2 + F, where F is the 5-bit field and phase 0 is the clock edge on which the frame-start pulse is high. This is a delay of F/4 bits (0 to 7 3/4) measured from a three-quarter sampling point.
- R4: With the mode input high, bit 0 is captured at phase 4·F[4:2] + F[1:0], where F[4:2] is the whole-bit delay (0 to 7) and F[1:0] = 00, 01, 10, 11 selects the 1/4, 2/4, 3/4 or 4/4 point of the cell.
- R5: After bit 0, bit k of the frame is captured exactly 4·k phases later, for k from 0 to FRAME_BITS−1. Each capture raises the valid strobe for exactly one cycle, in the cycle after the capture edge, with the index output equal to k. No further strobes follow in that frame.
- R6: While the valid strobe is high, the output bit equals the serial input value present at the capture edge.
- R7: The stream select, the mode input and the selected field are sampled only on a frame-start edge. A field write or a mode change made inside a frame does not alter that frame and applies from the next frame start. A write on the same edge as a frame start applies only to the frame after that one.
- R8: The stream select chooses which of the NUM_STREAMS fields governs the frame.
- R9: When a new frame captures its bit 0, every bit of the previous frame that is still pending is discarded. A frame start that arrives before the previous frame's bit 0 replaces that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| data_i | input | 1 | Serial input stream |
| frame_start_i | input | 1 | One-cycle pulse in the phase where bit 0 begins |
| split_mode_i | input | 1 | 0: fractional delay with fixed 3/4 point; 1: whole-bit delay plus selectable point |
| stream_sel_i | input | ADDR_W | Index of the field that governs the next frame |
| cfg_wr_en_i | input | 1 | Field write enable |
| cfg_wr_addr_i | input | ADDR_W | Field write index |
| cfg_wr_data_i | input | 16 | Write data; bits 4:0 used |
| cfg_rd_addr_i | input | ADDR_W | Field read index |
| cfg_rd_data_o | output | 16 | Read data, combinational from the read index |
| bit_o | output | 1 | Realigned bit |
| bit_valid_o | output | 1 | One-cycle strobe per captured bit |
| bit_idx_o | output | IDX_W | Index of the bit within its frame |

## Verification
Every field value from 0 to 31 is tried in both modes, back to back. Each frame selects a different entry that holds its own index, so a design that uses the wrong entry, drops an offset bit or mixes the two readings produces a different capture phase. The serial input is a hashed function of the cycle number, so the captured values show which of the four phases was sampled. Switching from the largest fractional delay to a zero split delay forces a new frame to cut off the tail of the old one. Mid-frame writes and mode flips show whether settings are captured only at frame boundaries.

// File: rtl/bit_delay_sampler_pkg.sv
// Shared constants and the phase-offset rule for the bit-delay sampler.
// Assumes a sampling clock at four phases per bit cell.
package bit_delay_sampler_pkg;

    localparam int FIELD_W = 5;   // delay field width
    localparam int CFG_W   = 16;  // configuration word width
    localparam int OFF_W   = 6;   // phase offset width (max 33)

    typedef enum logic {
        MODE_FRAC  = 1'b0,        // quarter-bit delay, fixed 3/4 point
        MODE_SPLIT = 1'b1         // whole-bit delay plus point select
    } samp_mode_e;

    // Phases from the frame-start edge to the capture of bit 0.
    function automatic logic [OFF_W-1:0] phase_offset(
        input samp_mode_e       mode,
        input logic [FIELD_W-1:0] fld
    );
        logic [OFF_W-1:0] whole;
        logic [OFF_W-1:0] point;
        if (mode == MODE_SPLIT) begin
            whole = {1'b0, fld[4:2], 2'b00};
            point = {4'b0000, fld[1:0]};
            return whole + point;
        end
        return {1'b0, fld} + OFF_W'(2);
    endfunction

endpackage

// File: rtl/delay_field_bank.sv
// Bank of per-stream delay fields.
// Holds NUM_STREAMS fields of FIELD_W bits with one write port, one
// configuration read port and one select port used by the frame logic.
// Assumes indices at or above NUM_STREAMS are neither written nor read
// (reads return zero).
module delay_field_bank
    import bit_delay_sampler_pkg::*;
#(
    parameter  int NUM_STREAMS = 32,
    localparam int ADDR_W      = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [FIELD_W-1:0] wr_field,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [FIELD_W-1:0] rd_field,
    input  logic [ADDR_W-1:0]  sel_addr,
    output logic [FIELD_W-1:0] sel_field
);

    logic [FIELD_W-1:0]     fld_q [NUM_STREAMS];
    logic [NUM_STREAMS-1:0] ent_we;

    // Decode one write enable per entry.
    for (genvar gi = 0; gi < NUM_STREAMS; gi++) begin : g_we
        assign ent_we[gi] = wr_en && (wr_addr == ADDR_W'(gi));
    end

    // Field storage: cleared by reset, loaded by its own enable.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_STREAMS; i++) begin
            if (!rst_n) begin
                fld_q[i] <= '0;
            end else if (ent_we[i]) begin
                fld_q[i] <= wr_field;
            end
        end
    end

    // Configuration read mux.
    always_comb begin
        rd_field = '0;
        for (int i = 0; i < NUM_STREAMS; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_field = fld_q[i];
        end
    end

    // Frame-select read mux.
    always_comb begin
        sel_field = '0;
        for (int i = 0; i < NUM_STREAMS; i++) begin
            if (sel_addr == ADDR_W'(i)) sel_field = fld_q[i];
        end
    end

    // R2
    // the low bits written to an entry are read back on the next cycle
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == rd_addr && $stable(rd_addr) && ($countones(ent_we) == 1))
            |=> rd_field == $past(wr_field));

endmodule

// File: rtl/frame_phase_arm.sv
// Frame-start arming logic.
// On a frame-start edge it computes the phase offset of bit 0 from the
// selected field and mode, then counts down the phases and issues a
// start pulse on the capture edge. An offset of zero starts on the
// frame-start edge itself. A new frame start always re-arms.
// Assumes frame_start_i is a single-cycle pulse.
module frame_phase_arm
    import bit_delay_sampler_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start_i,
    input  samp_mode_e         mode_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic               start_o
);

    logic [OFF_W-1:0] off_new;
    logic [OFF_W-1:0] cnt_q;
    logic             armed_q;

    // Offset requested by the settings present at this edge.
    always_comb off_new = phase_offset(mode_i, field_i);

    // Start pulse: immediate for zero offset, otherwise at countdown end.
    always_comb begin
        if (frame_start_i) begin
            start_o = (off_new == '0);
        end else begin
            start_o = armed_q && (cnt_q == '0);
        end
    end

    // Countdown of remaining phases until bit 0 capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (frame_start_i) begin
            armed_q <= (off_new != '0);
            cnt_q   <= off_new - OFF_W'(1);
        end else if (armed_q) begin
            if (cnt_q == '0) begin
                armed_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - OFF_W'(1);
            end
        end
    end

    // R9
    // an armed countdown fires once and then disarms unless re-armed
    arm_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !frame_start_i) |=> !start_o || frame_start_i);

endmodule

// File: rtl/cell_sampler.sv
// Bit-cell sampler.
// On a start pulse it captures bit 0, then captures one bit every four
// phases until FRAME_BITS bits are out. Each capture is presented for one
// cycle with a valid strobe and the bit index. A new start discards any
// bits still pending from the running frame.
// Assumes four clock phases per bit cell.
module cell_sampler #(
    parameter  int FRAME_BITS = 32,
    localparam int IDX_W      = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             data_i,
    output logic             bit_o,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic             running_q;
    logic [1:0]       quarter_q;
    logic [IDX_W-1:0] next_idx_q;

    // Run control: restart on start, step quarters while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q  <= 1'b0;
            quarter_q  <= '0;
            next_idx_q <= '0;
        end else if (start_i) begin
            running_q  <= (FRAME_BITS > 1);
            quarter_q  <= '0;
            next_idx_q <= IDX_W'(1);
        end else if (running_q) begin
            quarter_q <= quarter_q + 2'd1;
            if (quarter_q == 2'd3) begin
                next_idx_q <= next_idx_q + IDX_W'(1);
                if (next_idx_q == LAST_IDX) running_q <= 1'b0;
            end
        end
    end

    // Output register: capture the line on start or on each fourth phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            bit_o   <= 1'b0;
            idx_o   <= '0;
        end else if (start_i) begin
            valid_o <= 1'b1;
            bit_o   <= data_i;
            idx_o   <= '0;
        end else if (running_q && quarter_q == 2'd3) begin
            valid_o <= 1'b1;
            bit_o   <= data_i;
            idx_o   <= next_idx_q;
        end else begin
            valid_o <= 1'b0;
        end
    end

    // R5
    // a start yields bit 0 on the next cycle
    start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o && (idx_o == '0));

    // R5
    // strobes are isolated: one strobe is never followed directly by another
    // unless a new start intervenes
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !start_i) |=> !valid_o);

    // R6
    // the presented bit is the line value at the capture edge
    bit_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> bit_o == $past(data_i));

endmodule

// File: rtl/bit_delay_sampler.sv
// Programmable serial bit-delay sampler, top level.
// Ties the field bank, the frame arming counter and the cell sampler
// together. Stream select, mode and field are sampled on the frame-start
// edge only. The configuration port exposes bits 4:0 of each 16-bit word;
// the upper bits read as zero and are dropped on write.
// Assumes a clock at four phases per bit cell and a one-cycle frame pulse.
module bit_delay_sampler
    import bit_delay_sampler_pkg::*;
#(
    parameter  int NUM_STREAMS = 32,
    parameter  int FRAME_BITS  = 32,
    localparam int ADDR_W      = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
    localparam int IDX_W       = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_i,
    input  logic              frame_start_i,
    input  logic              split_mode_i,
    input  logic [ADDR_W-1:0] stream_sel_i,
    input  logic              cfg_wr_en_i,
    input  logic [ADDR_W-1:0] cfg_wr_addr_i,
    input  logic [CFG_W-1:0]  cfg_wr_data_i,
    input  logic [ADDR_W-1:0] cfg_rd_addr_i,
    output logic [CFG_W-1:0]  cfg_rd_data_o,
    output logic              bit_o,
    output logic              bit_valid_o,
    output logic [IDX_W-1:0]  bit_idx_o
);

    logic [FIELD_W-1:0] rd_field;
    logic [FIELD_W-1:0] sel_field;
    logic               start_pulse;
    samp_mode_e         mode;

    // Global mode input as the enumerated type.
    always_comb mode = samp_mode_e'(split_mode_i);

    // Reserved bits of the read word are zero.
    always_comb cfg_rd_data_o = {{(CFG_W-FIELD_W){1'b0}}, rd_field};

    delay_field_bank #(
        .NUM_STREAMS (NUM_STREAMS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en_i),
        .wr_addr   (cfg_wr_addr_i),
        .wr_field  (cfg_wr_data_i[FIELD_W-1:0]),
        .rd_addr   (cfg_rd_addr_i),
        .rd_field  (rd_field),
        .sel_addr  (stream_sel_i),
        .sel_field (sel_field)
    );

    frame_phase_arm u_arm (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start_i),
        .mode_i        (mode),
        .field_i       (sel_field),
        .start_o       (start_pulse)
    );

    cell_sampler #(
        .FRAME_BITS (FRAME_BITS)
    ) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_pulse),
        .data_i  (data_i),
        .bit_o   (bit_o),
        .valid_o (bit_valid_o),
        .idx_o   (bit_idx_o)
    );

    // Checker state: phases since the last frame start and its offset.
    logic [OFF_W-1:0] chk_phase_q;
    logic [OFF_W-1:0] chk_off_q;

    // Track the phase count and the latched offset for the timing check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_phase_q <= '0;
            chk_off_q   <= '0;
        end else if (frame_start_i) begin
            chk_phase_q <= OFF_W'(1);
            chk_off_q   <= phase_offset(mode, sel_field);
        end else if (chk_phase_q != '1) begin
            chk_phase_q <= chk_phase_q + OFF_W'(1);
        end
    end

    // R3 R4
    // a delayed start lands exactly on the offset latched at frame start
    start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && !frame_start_i) |-> chk_phase_q == chk_off_q);

    // R1
    // no strobe in the cycle after a reset edge
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !bit_valid_o);

    // R2
    // writes carrying reserved bits never make them visible on reads
    reserved_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en_i && (|cfg_wr_data_i[CFG_W-1:FIELD_W]))
            |=> cfg_rd_data_o[CFG_W-1:FIELD_W] == '0);

endmodule

// File: tb/tb_bit_delay_sampler.sv
module tb_bit_delay_sampler;

    localparam int NS = 32;
    localparam int FB = 32;
    localparam int AW = 5;
    localparam int IW = 5;
    localparam int PERIOD = 4 * FB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          data_i = 1'b0;
    logic          frame_start_i = 1'b0;
    logic          split_mode_i = 1'b0;
    logic [AW-1:0] stream_sel_i = '0;
    logic          cfg_wr_en_i = 1'b0;
    logic [AW-1:0] cfg_wr_addr_i = '0;
    logic [15:0]   cfg_wr_data_i = '0;
    logic [AW-1:0] cfg_rd_addr_i = '0;
    logic [15:0]   cfg_rd_data_o;
    logic          bit_o;
    logic          bit_valid_o;
    logic [IW-1:0] bit_idx_o;

    bit_delay_sampler #(.NUM_STREAMS(NS), .FRAME_BITS(FB)) dut (
        .clk(clk), .rst_n(rst_n), .data_i(data_i),
        .frame_start_i(frame_start_i), .split_mode_i(split_mode_i),
        .stream_sel_i(stream_sel_i), .cfg_wr_en_i(cfg_wr_en_i),
        .cfg_wr_addr_i(cfg_wr_addr_i), .cfg_wr_data_i(cfg_wr_data_i),
        .cfg_rd_addr_i(cfg_rd_addr_i), .cfg_rd_data_o(cfg_rd_data_o),
        .bit_o(bit_o), .bit_valid_o(bit_valid_o), .bit_idx_o(bit_idx_o)
    );

    always #5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    int    ecount = 0;
    string sect = "R8";
    int    model_fld [NS];
    int    cur_t, cur_o, prev_t, prev_o;
    bit    cur_m, prev_m, has_cur = 0, has_prev = 0;
    int    exp_total = 0, act_total = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Serial line value for a given capture edge.
    function automatic bit dval(input int e);
        logic [31:0] h;
        h = 32'(e) * 32'h9E3779B1;
        return h[19] ^ h[7];
    endfunction

    function automatic int offset_of(input bit m, input int f);
        if (m) return 4 * (f / 4) + (f % 4);
        return 2 + f;
    endfunction

    // Edge counter and line driver.
    always @(posedge clk) ecount <= ecount + 1;
    always @(negedge clk) data_i <= dval(ecount + 1);

    // Strobe monitor, sampled 2 ns after each rising edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            bit ev; int ek; bit em; int d;
            ev = 0; ek = 0; em = 0;
            if (has_cur && ecount >= cur_t + cur_o) begin
                d = ecount - cur_t - cur_o;
                if (d % 4 == 0 && d / 4 < FB) begin ev = 1; ek = d / 4; em = cur_m; end
            end else if (has_prev) begin
                d = ecount - prev_t - prev_o;
                if (d >= 0 && d % 4 == 0 && d / 4 < FB) begin ev = 1; ek = d / 4; em = prev_m; end
            end
            if (ev) exp_total++;
            if (bit_valid_o) act_total++;
            if (ev || bit_valid_o) begin
                check(bit_valid_o == ev && (!ev || int'(bit_idx_o) == ek),
                      {em ? "R4/" : "R3/", sect}, "strobe index",
                      bit_valid_o ? int'(bit_idx_o) : -1, ev ? ek : -1);
                if (ev && bit_valid_o)
                    check(bit_o == dval(ecount), "R6", "bit value",
                          int'(bit_o), int'(dval(ecount)));
            end
        end
    end

    task automatic cfg_write(input int a, input logic [15:0] w);
        @(negedge clk);
        cfg_wr_en_i = 1; cfg_wr_addr_i = AW'(a); cfg_wr_data_i = w;
        model_fld[a] = int'(w[4:0]);
        @(negedge clk);
        cfg_wr_en_i = 0;
    endtask

    task automatic cfg_read_check(input int a, input string req);
        @(negedge clk);
        cfg_rd_addr_i = AW'(a);
        #1;
        check(cfg_rd_data_o == 16'(model_fld[a]), req, "read word",
              int'(cfg_rd_data_o), model_fld[a]);
    endtask

    // One frame of PERIOD phases; optional mid-frame write and mode flip.
    task automatic run_frame(input int sel, input bit m, input bit mid,
                             input int mid_val, input bit mid_mode);
        @(negedge clk);
        stream_sel_i = AW'(sel); split_mode_i = m; frame_start_i = 1;
        prev_t = cur_t; prev_o = cur_o; prev_m = cur_m; has_prev = has_cur;
        cur_t = ecount + 1; cur_o = offset_of(m, model_fld[sel]); cur_m = m;
        has_cur = 1;
        @(negedge clk);
        frame_start_i = 0;
        if (mid) begin
            repeat (8) @(negedge clk);
            cfg_write(sel, 16'(mid_val));
            split_mode_i = mid_mode;
            stream_sel_i = AW'((sel + 1) % NS);
            repeat (PERIOD - 12) @(negedge clk);
        end else begin
            repeat (PERIOD - 2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        check(0, "R5", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < NS; i++) model_fld[i] = 0;
        cur_t = 0; cur_o = 0; cur_m = 0; prev_t = 0; prev_o = 0; prev_m = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        for (int i = 0; i < NS; i++) cfg_read_check(i, "R1");
        repeat (6) @(negedge clk);
        check(bit_valid_o == 0, "R1", "strobe before first frame", int'(bit_valid_o), 0);
        // R2: reserved bits dropped, field read back
        for (int i = 0; i < NS; i++) cfg_write(i, 16'hFFE0 | 16'(i));
        for (int i = 0; i < NS; i++) cfg_read_check(i, "R2");
        cfg_write(5, 16'hFFFF);
        cfg_read_check(5, "R2");
        cfg_write(5, 16'h0005);
        cfg_read_check(5, "R2");
        // R3 R8: fractional sweep, stream i holds value i
        sect = "R8";
        for (int f = 0; f < NS; f++) run_frame(f, 0, 0, 0, 0);
        // R4 R8 R9: split sweep; first frame cuts off the long tail
        for (int f = 0; f < NS; f++) begin
            sect = (f == 0) ? "R9" : "R8";
            run_frame(f, 1, 0, 0, 0);
        end
        // R7: mid-frame writes and mode flips apply from the next frame
        sect = "R7";
        run_frame(3, 0, 1, 20, 1);
        run_frame(3, 1, 1, 3, 0);
        run_frame(3, 0, 1, 31, 0);
        run_frame(3, 0, 0, 0, 0);
        repeat (PERIOD + 60) @(negedge clk);
        // R5: total strobe count
        check(act_total == exp_total, "R5", "total strobes", act_total, exp_total);
        finish_run();
    end

endmodule